// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block performs the architectural state change that happens when a processor core takes an exception. The core presents an accepted exception code with a one-cycle strobe, together with the current machine state register (MSR), the current instruction address and a vector-base prefix. One clock later the block has written a save register pair (return address and saved MSR), and has produced the MSR that the handler runs under and the address from which the handler is fetched. Critical input uses a second save pair of its own, so the normal pair survives a critical interrupt.

Each supported exception is classified either as restartable, where the faulting instruction's address (current address minus 4) is saved, or as completing, where the next address is saved. Program exceptions record their sub-cause in the saved MSR. A floating-point program exception that the MSR does not enable is discarded. A machine check that arrives while machine checks are disabled halts the unit in a checkstop state until reset. A return path restores the address and MSR from either save pair.

Top module: `exc_entry_unit`

## Requirements
- R1: An entry with a defined code raises `done` for exactly one cycle, in the cycle after the `req_valid` strobe, and the save registers, `hnd_msr` and `hnd_pc` hold their new values in that same cycle. If `req_valid` and `rfi_valid` arrive together, the entry is taken and the return is ignored.
- R2: The saved MSR equals the current MSR with mask 0x783F0000 cleared, ORed with cause bits. For a program exception (code 5), `req_sub` selects the cause: 0 floating-point enabled sets 0x00100000, 1 illegal sets 0x00080000, 2 privileged sets 0x00040000, and 3 trap sets 0x00020000.
- R3: Codes program (5), alignment (6), FP-unavailable (7) and auxiliary-unavailable (10) save `cur_pc - 4`. Reset (1), machine check (2), critical (3), external (4), system call (8) and decrementer (9) save `cur_pc`.
- R4: The handler MSR is zero except for two bits. ME (bit 12) is copied from the current MSR, and LE (bit 0) is set when ILE (bit 16) of the current MSR is set.
- R5: The handler address is the code times 0x100, zero-extended, ORed with `vec_prefix`.
- R6: A machine check clears ME in the handler MSR. If ME is 0 when the machine check arrives, `checkstop` rises and stays high until reset, no register is updated, and every later entry or return request is ignored.
- R7: A floating-point program exception (sub 0) is discarded with no output change when FP (bit 13) is 0, or when FE0 (bit 11) and FE1 (bit 8) are both 0. When FE0 differs from FE1, 0x00010000 is also set in the saved MSR.
- R8: A system reset taken with POW (bit 18) set adds 0x00010000 to the saved MSR. A reset taken with POW clear clears ME in the handler MSR.
- R9: Critical input (code 3) writes only the critical save pair (`csrr_pc`, `csrr_msr`). The normal pair is left unchanged.
- R10: Codes 0 and 11 to 15 have no vector. They pulse `err` for one cycle, do not raise `done`, and leave every state output unchanged.
- R11: A `rfi_valid` strobe with `rfi_crit` = 0 loads `hnd_pc` with `srr_pc` with its low two bits cleared, and `hnd_msr` with `srr_msr` with mask 0x783F0000 cleared. With `rfi_crit` = 1, it loads the critical pair, where the address has its low two bits cleared and the MSR is taken unmasked. `ret_done` pulses in the cycle after the strobe.
- R12: After synchronous reset, every output register is zero and `checkstop` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Exception entry strobe |
| req_code | input | CODE_W | Exception code |
| req_sub | input | 2 | Program-exception sub-cause |
| cur_msr | input | XLEN | Current MSR |
| cur_pc | input | XLEN | Current instruction address |
| vec_prefix | input | XLEN | Vector base prefix |
| rfi_valid | input | 1 | Return-from-interrupt strobe |
| rfi_crit | input | 1 | Return from the critical pair |
| done | output | 1 | Entry completed |
| ret_done | output | 1 | Return completed |
| err | output | 1 | Code without a vector |
| checkstop | output | 1 | Halted after a disabled machine check |
| hnd_msr | output | XLEN | New MSR |
| hnd_pc | output | XLEN | Fetch address |
| srr_pc | output | XLEN | Saved return address |
| srr_msr | output | XLEN | Saved MSR |
| csrr_pc | output | XLEN | Critical saved return address |
| csrr_msr | output | XLEN | Critical saved MSR |

## Verification
The hardest situation to reach is the checkstop. It needs a machine check presented with ME clear, and after it the unit must ignore all further traffic. The stimulus drives that machine check after the normal pairs hold known values, then issues an external entry and a return. It confirms that neither changes any output and that only reset clears the halt. The discard of an FP program exception is reached in the same directed way, with two MSR combinations (FP off, and both enables off), and the save registers are compared before and after.

// File: rtl/exc_pkg.sv
package exc_pkg;

  // exception codes
  localparam int C_RESET = 1;
  localparam int C_MCHK  = 2;
  localparam int C_CRIT  = 3;
  localparam int C_EXT   = 4;
  localparam int C_PROG  = 5;
  localparam int C_ALIGN = 6;
  localparam int C_FPUN  = 7;
  localparam int C_SYSC  = 8;
  localparam int C_DEC   = 9;
  localparam int C_AUXUN = 10;

  // MSR bit positions
  localparam int B_LE   = 0;
  localparam int B_FE1  = 8;
  localparam int B_FE0  = 11;
  localparam int B_ME   = 12;
  localparam int B_FP   = 13;
  localparam int B_ILE  = 16;
  localparam int B_POW  = 18;

  localparam logic [31:0] MBZ_MASK  = 32'h783F_0000;
  localparam int          CAUSE_LSB = 16;
  localparam int          CAUSE_W   = 5;
  localparam int          VEC_SHIFT = 8;

  typedef enum logic [1:0] {
    PS_FP   = 2'd0,
    PS_ILL  = 2'd1,
    PS_PRIV = 2'd2,
    PS_TRAP = 2'd3
  } prog_sub_e;

  typedef struct packed {
    logic               invalid;
    logic               drop;
    logic               fatal;
    logic               crit;
    logic               save_cur;
    logic               clr_me;
    logic [CAUSE_W-1:0] cause;
  } exc_plan_t;

  function automatic logic code_has_vector(input int c);
    return (c >= C_RESET) && (c <= C_AUXUN);
  endfunction

endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int OFF_W  = 16
) (
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        sub,
  input  logic              me,
  input  logic              pow,
  input  logic              fp,
  input  logic              fe0,
  input  logic              fe1,
  output exc_plan_t         plan,
  output logic [OFF_W-1:0]  vec_off
);

  localparam int NCODES = 1 << CODE_W;

  logic [OFF_W-1:0]  vec_rom [NCODES];
  logic [NCODES-1:0] vec_def;

  // per-code vector offsets, computed from the code value
  for (genvar i = 0; i < NCODES; i++) begin : g_vec
    assign vec_def[i] = code_has_vector(i);
    assign vec_rom[i] = vec_def[i] ? (OFF_W'(i) << VEC_SHIFT) : '0;
  end

  assign vec_off = vec_rom[code];

  always_comb begin
    plan         = '0;
    plan.invalid = !vec_def[code];
    case (code)
      CODE_W'(C_RESET): begin
        if (pow) plan.cause = 5'b00001;
        else     plan.clr_me = 1'b1;
      end
      CODE_W'(C_MCHK): begin
        plan.clr_me = 1'b1;
        plan.fatal  = !me;
      end
      CODE_W'(C_CRIT): plan.crit = 1'b1;
      CODE_W'(C_PROG): begin
        plan.save_cur = 1'b1;
        case (prog_sub_e'(sub))
          PS_FP: begin
            plan.drop  = !fp || (!fe0 && !fe1);
            plan.cause = (fe0 != fe1) ? 5'b10001 : 5'b10000;
          end
          PS_ILL:  plan.cause = 5'b01000;
          PS_PRIV: plan.cause = 5'b00100;
          default: plan.cause = 5'b00010;
        endcase
      end
      CODE_W'(C_ALIGN), CODE_W'(C_FPUN), CODE_W'(C_AUXUN): plan.save_cur = 1'b1;
      default: ;
    endcase
  end

endmodule

// File: rtl/exc_msr_build.sv
module exc_msr_build
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] cur_msr,
  input  exc_plan_t       plan,
  output logic [XLEN-1:0] saved_msr,
  output logic [XLEN-1:0] new_msr
);

  localparam logic [XLEN-1:0] MBZ = XLEN'(MBZ_MASK);

  always_comb begin
    saved_msr = (cur_msr & ~MBZ) | (XLEN'(plan.cause) << CAUSE_LSB);
    new_msr          = '0;
    new_msr[B_ME]    = cur_msr[B_ME] & !plan.clr_me;
    new_msr[B_LE]    = cur_msr[B_ILE];
  end

endmodule

// File: rtl/exc_state_regs.sv
module exc_state_regs
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            do_entry,
  input  logic            to_crit,
  input  logic            do_err,
  input  logic            do_stop,
  input  logic            do_ret,
  input  logic            ret_crit,
  input  logic [XLEN-1:0] save_pc,
  input  logic [XLEN-1:0] saved_msr,
  input  logic [XLEN-1:0] new_msr,
  input  logic [XLEN-1:0] new_pc,
  output logic            done,
  output logic            ret_done,
  output logic            err,
  output logic            checkstop,
  output logic [XLEN-1:0] hnd_msr,
  output logic [XLEN-1:0] hnd_pc,
  output logic [XLEN-1:0] srr_pc,
  output logic [XLEN-1:0] srr_msr,
  output logic [XLEN-1:0] csrr_pc,
  output logic [XLEN-1:0] csrr_msr
);

  localparam logic [XLEN-1:0] MBZ     = XLEN'(MBZ_MASK);
  localparam logic [XLEN-1:0] PC_ALGN = ~XLEN'(3);

  logic [XLEN-1:0] ret_pc, ret_msr;

  always_comb begin
    ret_pc  = (ret_crit ? csrr_pc : srr_pc) & PC_ALGN;
    ret_msr = ret_crit ? csrr_msr : (srr_msr & ~MBZ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done      <= 1'b0;
      ret_done  <= 1'b0;
      err       <= 1'b0;
      checkstop <= 1'b0;
      hnd_msr   <= '0;
      hnd_pc    <= '0;
      srr_pc    <= '0;
      srr_msr   <= '0;
      csrr_pc   <= '0;
      csrr_msr  <= '0;
    end else begin
      done     <= do_entry;
      ret_done <= do_ret;
      err      <= do_err;
      if (do_stop) checkstop <= 1'b1;
      if (do_entry) begin
        hnd_msr <= new_msr;
        hnd_pc  <= new_pc;
        if (to_crit) begin
          csrr_pc  <= save_pc;
          csrr_msr <= saved_msr;
        end else begin
          srr_pc  <= save_pc;
          srr_msr <= saved_msr;
        end
      end else if (do_ret) begin
        hnd_msr <= ret_msr;
        hnd_pc  <= ret_pc;
      end
    end
  end

  assert_checkstop_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    checkstop |=> checkstop);

  assert_err_keeps_state_R10: assert property (@(posedge clk) disable iff (rst)
    err |-> ($stable(srr_pc) && $stable(srr_msr) && $stable(hnd_pc) && $stable(hnd_msr)));

  assert_ret_aligned_R11: assert property (@(posedge clk) disable iff (rst)
    ret_done |-> (hnd_pc[1:0] == 2'b00));

  assert_hnd_msr_bits_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> ((hnd_msr & ~((XLEN'(1) << B_ME) | (XLEN'(1) << B_LE))) == '0));

  assert_single_event_R1: assert property (@(posedge clk) disable iff (rst)
    $countones({done, ret_done, err}) <= 1);

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 4,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] req_code,
  input  logic [1:0]        req_sub,
  input  logic [XLEN-1:0]   cur_msr,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   vec_prefix,
  input  logic              rfi_valid,
  input  logic              rfi_crit,
  output logic              done,
  output logic              ret_done,
  output logic              err,
  output logic              checkstop,
  output logic [XLEN-1:0]   hnd_msr,
  output logic [XLEN-1:0]   hnd_pc,
  output logic [XLEN-1:0]   srr_pc,
  output logic [XLEN-1:0]   srr_msr,
  output logic [XLEN-1:0]   csrr_pc,
  output logic [XLEN-1:0]   csrr_msr
);

  exc_plan_t        plan;
  logic [OFF_W-1:0] vec_off;
  logic [XLEN-1:0]  saved_msr, new_msr, save_pc, new_pc;
  logic             accept, do_entry, do_err, do_stop, do_ret;

  exc_classify #(.CODE_W(CODE_W), .OFF_W(OFF_W)) u_classify (
    .code    (req_code),
    .sub     (req_sub),
    .me      (cur_msr[B_ME]),
    .pow     (cur_msr[B_POW]),
    .fp      (cur_msr[B_FP]),
    .fe0     (cur_msr[B_FE0]),
    .fe1     (cur_msr[B_FE1]),
    .plan    (plan),
    .vec_off (vec_off)
  );

  exc_msr_build #(.XLEN(XLEN)) u_msr (
    .cur_msr   (cur_msr),
    .plan      (plan),
    .saved_msr (saved_msr),
    .new_msr   (new_msr)
  );

  always_comb begin
    accept   = req_valid && !checkstop;
    do_entry = accept && !plan.invalid && !plan.drop && !plan.fatal;
    do_err   = accept && plan.invalid;
    do_stop  = accept && plan.fatal;
    do_ret   = rfi_valid && !req_valid && !checkstop;
    save_pc  = plan.save_cur ? (cur_pc - XLEN'(4)) : cur_pc;
    new_pc   = XLEN'(vec_off) | vec_prefix;
  end

  exc_state_regs #(.XLEN(XLEN)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .do_entry  (do_entry),
    .to_crit   (plan.crit),
    .do_err    (do_err),
    .do_stop   (do_stop),
    .do_ret    (do_ret),
    .ret_crit  (rfi_crit),
    .save_pc   (save_pc),
    .saved_msr (saved_msr),
    .new_msr   (new_msr),
    .new_pc    (new_pc),
    .done      (done),
    .ret_done  (ret_done),
    .err       (err),
    .checkstop (checkstop),
    .hnd_msr   (hnd_msr),
    .hnd_pc    (hnd_pc),
    .srr_pc    (srr_pc),
    .srr_msr   (srr_msr),
    .csrr_pc   (csrr_pc),
    .csrr_msr  (csrr_msr)
  );

  assert_mchk_clears_me_R6: assert property (@(posedge clk) disable iff (rst)
    (done && $past(req_code) == CODE_W'(C_MCHK)) |-> !hnd_msr[B_ME]);

  assert_done_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(req_valid));

  assert_stop_blocks_done_R6: assert property (@(posedge clk) disable iff (rst)
    $past(checkstop) |-> (!done && !ret_done));

endmodule

// File: tb/exc_entry_unit_bench.sv
module exc_entry_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [3:0]  req_code = '0;
  logic [1:0]  req_sub = '0;
  logic [31:0] cur_msr = '0, cur_pc = '0;
  logic [31:0] vec_prefix = 32'hFFF0_0000;
  logic        rfi_valid = 1'b0, rfi_crit = 1'b0;
  logic        done, ret_done, err, checkstop;
  logic [31:0] hnd_msr, hnd_pc, srr_pc, srr_msr, csrr_pc, csrr_msr;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  exc_entry_unit u_exc_entry_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_code(req_code),
    .req_sub(req_sub), .cur_msr(cur_msr), .cur_pc(cur_pc),
    .vec_prefix(vec_prefix), .rfi_valid(rfi_valid), .rfi_crit(rfi_crit),
    .done(done), .ret_done(ret_done), .err(err), .checkstop(checkstop),
    .hnd_msr(hnd_msr), .hnd_pc(hnd_pc), .srr_pc(srr_pc), .srr_msr(srr_msr),
    .csrr_pc(csrr_pc), .csrr_msr(csrr_msr)
  );

  // {code, sub, msr, pc}
  localparam int NV = 14;
  localparam logic [69:0] VECS [NV] = '{
    {4'd1,  2'd0, 32'h0004_1000, 32'h0000_0100},
    {4'd1,  2'd0, 32'h0001_1000, 32'h0000_0140},
    {4'd2,  2'd0, 32'h0000_9030, 32'h0000_1180},
    {4'd4,  2'd0, 32'hFFFF_FFFF, 32'h0000_2000},
    {4'd5,  2'd0, 32'h0000_3800, 32'h0000_2044},
    {4'd5,  2'd0, 32'h0000_3900, 32'h0000_2088},
    {4'd5,  2'd1, 32'h8000_0000, 32'h0000_30C0},
    {4'd5,  2'd2, 32'h0000_1004, 32'h0000_3100},
    {4'd5,  2'd3, 32'h783F_0000, 32'h0000_3144},
    {4'd6,  2'd0, 32'h1234_5678, 32'h0000_4000},
    {4'd7,  2'd0, 32'h0000_0000, 32'h0000_4010},
    {4'd8,  2'd0, 32'h0001_0000, 32'h0000_5008},
    {4'd9,  2'd0, 32'hAAAA_AAAA, 32'h0000_600C},
    {4'd10, 2'd0, 32'h5555_5555, 32'h0000_7000}
  };

  logic [31:0] e_spc, e_smsr, e_nmsr, e_npc, e_cpc, e_cmsr;

  // reference model built from the requirements
  task automatic model(input logic [3:0] c, input logic [1:0] s, input logic [31:0] m,
                       input logic [31:0] p, output logic [31:0] spc, output logic [31:0] smsr,
                       output logic [31:0] nmsr, output logic [31:0] npc);
    logic [31:0] cause = 32'h0;
    logic me = m[12];
    if (c == 4'd5) begin
      case (s)
        2'd0: cause = 32'h0010_0000 | ((m[11] != m[8]) ? 32'h0001_0000 : 32'h0);
        2'd1: cause = 32'h0008_0000;
        2'd2: cause = 32'h0004_0000;
        default: cause = 32'h0002_0000;
      endcase
    end
    if (c == 4'd1 && m[18]) cause = 32'h0001_0000;
    if (c == 4'd2 || (c == 4'd1 && !m[18])) me = 1'b0;
    smsr = (m & ~32'h783F_0000) | cause;
    nmsr = {19'd0, me, 11'd0, m[16]};
    npc  = ({24'd0, c, 4'd0} << 4) | vec_prefix;
    spc  = (c == 4'd5 || c == 4'd6 || c == 4'd7 || c == 4'd10) ? p - 32'd4 : p;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the capturing edge
  task automatic req(input logic [3:0] c, input logic [1:0] s, input logic [31:0] m,
                     input logic [31:0] p);
    req_valid = 1'b1; req_code = c; req_sub = s; cur_msr = m; cur_pc = p;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ret(input logic crit);
    rfi_valid = 1'b1; rfi_crit = crit;
    @(negedge clk);
    rfi_valid = 1'b0;
  endtask

  task automatic state_same(input string tag);
    chk({tag, " srr_pc"},  srr_pc,  e_spc);
    chk({tag, " srr_msr"}, srr_msr, e_smsr);
    chk({tag, " hnd_msr"}, hnd_msr, e_nmsr);
    chk({tag, " hnd_pc"},  hnd_pc,  e_npc);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk("R12 done", {31'd0, done}, 32'd0);
    chk("R12 checkstop", {31'd0, checkstop}, 32'd0);
    chk("R12 hnd_pc", hnd_pc, 32'd0);
    chk("R12 srr_msr", srr_msr, 32'd0);
    chk("R12 csrr_pc", csrr_pc, 32'd0);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      logic [3:0] c; logic [1:0] s; logic [31:0] m, p;
      {c, s, m, p} = VECS[i];
      model(c, s, m, p, e_spc, e_smsr, e_nmsr, e_npc);
      req(c, s, m, p);
      chk($sformatf("R1 done v%0d", i), {31'd0, done}, 32'd1);
      chk($sformatf("R3 srr_pc v%0d", i), srr_pc, e_spc);
      chk($sformatf("R2/R7/R8 srr_msr v%0d", i), srr_msr, e_smsr);
      chk($sformatf("R4/R6/R8 hnd_msr v%0d", i), hnd_msr, e_nmsr);
      chk($sformatf("R5 hnd_pc v%0d", i), hnd_pc, e_npc);
      chk($sformatf("R9 csrr_pc v%0d", i), csrr_pc, 32'd0);
      @(negedge clk);
      chk($sformatf("R1 done one cycle v%0d", i), {31'd0, done}, 32'd0);
    end

    // R9 critical pair
    req(4'd3, 2'd0, 32'h0001_1000, 32'h0000_4003);
    chk("R9 csrr_pc", csrr_pc, 32'h0000_4003);
    chk("R9 csrr_msr", csrr_msr, 32'h0000_1000);
    chk("R9 srr_pc kept", srr_pc, e_spc);
    chk("R9 srr_msr kept", srr_msr, e_smsr);
    chk("R9 hnd_pc", hnd_pc, 32'hFFF0_0300);
    chk("R9 hnd_msr", hnd_msr, 32'h0000_1001);
    e_nmsr = hnd_msr; e_npc = hnd_pc;

    // R10 undefined codes
    req(4'd12, 2'd0, 32'h0000_1000, 32'h0000_9000);
    chk("R10 err", {31'd0, err}, 32'd1);
    chk("R10 done", {31'd0, done}, 32'd0);
    state_same("R10 code12");
    req(4'd0, 2'd0, 32'h0000_1000, 32'h0000_9100);
    chk("R10 err code0", {31'd0, err}, 32'd1);
    state_same("R10 code0");

    // R7 discarded FP program exceptions
    req(4'd5, 2'd0, 32'h0000_3000, 32'h0000_A000);
    chk("R7 drop enables off done", {31'd0, done | err}, 32'd0);
    state_same("R7 enables off");
    req(4'd5, 2'd0, 32'h0000_0900, 32'h0000_A100);
    chk("R7 drop fp off done", {31'd0, done | err}, 32'd0);
    state_same("R7 fp off");

    // R11 normal return
    req(4'd5, 2'd3, 32'h0001_9003, 32'h0000_600B);
    chk("R11 entry srr_msr", srr_msr, 32'h0002_9003);
    chk("R11 entry srr_pc", srr_pc, 32'h0000_6007);
    ret(1'b0);
    chk("R11 ret_done", {31'd0, ret_done}, 32'd1);
    chk("R11 ret pc", hnd_pc, 32'h0000_6004);
    chk("R11 ret msr", hnd_msr, 32'h0000_9003);
    // R11 critical return
    ret(1'b1);
    chk("R11 crit ret pc", hnd_pc, 32'h0000_4000);
    chk("R11 crit ret msr", hnd_msr, 32'h0000_1000);

    // R1 entry wins over return
    rfi_valid = 1'b1; rfi_crit = 1'b0;
    req(4'd8, 2'd0, 32'h0000_1000, 32'h0000_B000);
    rfi_valid = 1'b0;
    chk("R1 priority done", {31'd0, done}, 32'd1);
    chk("R1 priority ret_done", {31'd0, ret_done}, 32'd0);
    chk("R1 priority hnd_pc", hnd_pc, 32'hFFF0_0800);
    e_spc = srr_pc; e_smsr = srr_msr; e_nmsr = hnd_msr; e_npc = hnd_pc;

    // R6 checkstop
    req(4'd2, 2'd0, 32'h0000_0030, 32'h0000_C000);
    chk("R6 checkstop", {31'd0, checkstop}, 32'd1);
    chk("R6 no done", {31'd0, done}, 32'd0);
    state_same("R6 stop");
    req(4'd4, 2'd0, 32'h0000_1000, 32'h0000_C100);
    ret(1'b0);
    chk("R6 still stopped", {31'd0, checkstop}, 32'd1);
    chk("R6 ignored done", {31'd0, done | ret_done}, 32'd0);
    state_same("R6 ignored");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R6/R12 reset clears checkstop", {31'd0, checkstop}, 32'd0);
    chk("R12 srr_pc after reset", srr_pc, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule